// File: doc/BRIEF.md
# Endpoint FIFO access controller

This block sits between a local processor and two 8-bit endpoint FIFOs, pipe 0 and pipe 1, that a USB host engine shares with it. The processor drives everything through one control byte and one data byte. It writes a control byte that raises a request flag and names the pipe and the direction. It then polls a ready flag in the status byte. It moves bytes through the data port, and it finishes by dropping the request flag. A minimum spacing, set in clock cycles, is enforced after the request and after every accepted data byte. An access that comes too early is dropped and leaves a sticky error flag.

The host engine is modelled as a simple port. It claims a pipe through an ownership mask and pushes or pops bytes on pipes it owns. It signals the end of each transfer with a strobe and the pipe number. A pipe that the host owns is never ready for the processor. When a transfer ends, the block pulses an interrupt and latches the pipe number. A write-direction access that is released without moving any bytes marks a zero-length packet pending on that pipe, and the host's next finished transfer on that pipe clears the mark.

Top module: `ep_fifo_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `usb_irq` is 0, `act_pipe` is 0, `zlp_pend` is 00b and both FIFOs are empty.
- R2: Status byte layout: bits 5..0 echo bits 5..0 of the last control write (bit 0 request, bit 1 write direction or zero-length mode, bit 3 pipe select), bit 6 is the ready flag, bit 7 is the sticky gap error. Writing bit 6 has no effect.
- R3: Ready stays 0 for MIN_GAP cycles after the request bit rises and for MIN_GAP cycles after each accepted data byte.
- R4: A data-port read or write made while that spacing is still running is ignored and sets status bit 7. Bit 7 is cleared only by a control write with bit 7 set.
- R5: For a read access, ready also needs the selected FIFO to be non-empty. Accepted reads return the FIFO bytes in arrival order on `dat_rdata`, updated one cycle after the strobe.
- R6: While `host_own` has the selected pipe's bit set, ready is 0 and processor data accesses are ignored. Host push or pop on a pipe it does not own is ignored.
- R7: A `host_done` strobe gives a one-cycle `usb_irq` pulse in the next cycle, and `act_pipe` then holds the `host_pipe` value given with the strobe.
- R8: Releasing a write-direction access (request bit 1 to 0) with no byte accepted sets `zlp_pend` for that pipe. A `host_done` on that pipe clears the flag. Releasing a read access sets nothing.
- R9: Pipe and direction are latched when the request bit rises. Control writes that keep the request bit high do not change them.
- R10: Each FIFO holds DEPTH bytes. For a write access, ready needs room in the FIFO, and a write made when the FIFO is full is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ctl_rdata | output | 8 | Status byte |
| dat_rd | input | 1 | Data port read strobe |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | DW | Byte to push |
| dat_rdata | output | DW | Last byte popped by the processor |
| host_own | input | 2 | Host ownership mask, one bit per pipe |
| host_ep | input | 1 | Pipe addressed by host push or pop |
| host_push | input | 1 | Host push strobe |
| host_wdata | input | DW | Host push byte |
| host_pop | input | 1 | Host pop strobe |
| host_rdata | output | DW | Head byte of pipe `host_ep` |
| host_level | output | clog2(DEPTH+1) | Fill level of pipe `host_ep` |
| host_done | input | 1 | Host transfer finished strobe |
| host_pipe | input | 1 | Pipe that finished |
| usb_irq | output | 1 | Transfer-finished interrupt pulse |
| act_pipe | output | 1 | Number of the last finished pipe |
| zlp_pend | output | 2 | Zero-length packet pending, one bit per pipe |

## Verification
Status and FIFO levels are combinational on registered state, so they are checked in the half cycle after the edge that took the control write or strobe. `dat_rdata`, `usb_irq`, `act_pipe` and `zlp_pend` are registered, so they are checked one edge after their strobe. All checks fall on the falling clock edge after the edge that is due. The ready boundary is probed at exactly MIN_GAP-1 and MIN_GAP cycles after the request edge. Expected read bytes go into a queue when each read is driven. A monitor pops the queue at the falling edge after each expected-accepted strobe.

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int MIN_GAP = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_wr,
  input  logic [7:0]                   ctl_wdata,
  output logic [7:0]                   ctl_rdata,
  input  logic                         dat_rd,
  input  logic                         dat_wr,
  input  logic [DW-1:0]                dat_wdata,
  output logic [DW-1:0]                dat_rdata,
  input  logic [1:0]                   host_own,
  input  logic                         host_ep,
  input  logic                         host_push,
  input  logic [DW-1:0]                host_wdata,
  input  logic                         host_pop,
  output logic [DW-1:0]                host_rdata,
  output logic [$clog2(DEPTH+1)-1:0]   host_level,
  input  logic                         host_done,
  input  logic                         host_pipe,
  output logic                         usb_irq,
  output logic                         act_pipe,
  output logic [1:0]                   zlp_pend
);
  localparam int NEP = 2;
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH+1);
  localparam int GW  = $clog2(MIN_GAP+1);

  logic [5:0]    ctl_q;
  logic          act_ep, act_wr, moved, err;
  logic [GW-1:0] gap;
  logic [DW-1:0] mem [NEP][DEPTH];
  logic [AW-1:0] rp [NEP];
  logic [AW-1:0] wp [NEP];
  logic [CW-1:0] cnt [NEP];
  logic [NEP-1:0] push_e, pop_e, h_push, h_pop, c_push, c_pop;

  logic unused_bit6;
  assign unused_bit6 = ctl_wdata[6];

  wire active   = ctl_q[0];
  wire gap_ok   = (gap == '0);
  wire fifo_ok  = act_wr ? (cnt[act_ep] != CW'(DEPTH)) : (cnt[act_ep] != '0);
  wire rdy      = active & gap_ok & ~host_own[act_ep] & fifo_ok;
  wire req_rise = ctl_wr & ctl_wdata[0] & ~ctl_q[0];
  wire req_fall = ctl_wr & ~ctl_wdata[0] & ctl_q[0];
  wire cpu_try  = active & ((dat_rd & ~act_wr) | (dat_wr & act_wr));
  wire early    = cpu_try & ~gap_ok;
  wire cpu_go   = cpu_try & rdy;

  assign ctl_rdata  = {err, rdy, ctl_q};
  assign host_rdata = mem[host_ep][rp[host_ep]];
  assign host_level = cnt[host_ep];

  for (genvar e = 0; e < NEP; e++) begin : g_ep
    assign h_push[e] = host_push & (host_ep == e[0]) & host_own[e] & (cnt[e] != CW'(DEPTH));
    assign h_pop[e]  = host_pop  & (host_ep == e[0]) & host_own[e] & (cnt[e] != '0);
    assign c_push[e] = cpu_go &  act_wr & (act_ep == e[0]);
    assign c_pop[e]  = cpu_go & ~act_wr & (act_ep == e[0]);
    assign push_e[e] = h_push[e] | c_push[e];
    assign pop_e[e]  = h_pop[e] | c_pop[e];

    always_ff @(posedge clk)
      if (push_e[e]) mem[e][wp[e]] <= c_push[e] ? dat_wdata : host_wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rp[e]  <= '0;
        wp[e]  <= '0;
        cnt[e] <= '0;
      end else begin
        if (push_e[e]) wp[e] <= (wp[e] == AW'(DEPTH-1)) ? '0 : wp[e] + 1'b1;
        if (pop_e[e])  rp[e] <= (rp[e] == AW'(DEPTH-1)) ? '0 : rp[e] + 1'b1;
        cnt[e] <= cnt[e] + CW'(push_e[e]) - CW'(pop_e[e]);
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) zlp_pend[e] <= 1'b0;
      else if (req_fall && act_wr && !moved && act_ep == e[0]) zlp_pend[e] <= 1'b1;
      else if (host_done && host_pipe == e[0]) zlp_pend[e] <= 1'b0;

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[e] == CW'(DEPTH)) |-> !(push_e[e] && !pop_e[e]));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[e] == '0) |-> !pop_e[e]);
    p_host_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_own[e] |-> !(c_push[e] || c_pop[e]));
    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !((h_push[e] || h_pop[e]) && (c_push[e] || c_pop[e])));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q     <= '0;
      act_ep    <= 1'b0;
      act_wr    <= 1'b0;
      moved     <= 1'b0;
      err       <= 1'b0;
      gap       <= '0;
      dat_rdata <= '0;
      usb_irq   <= 1'b0;
      act_pipe  <= 1'b0;
    end else begin
      usb_irq <= host_done;
      if (host_done) act_pipe <= host_pipe;
      if (ctl_wr) begin
        ctl_q <= ctl_wdata[5:0];
        if (ctl_wdata[7]) err <= 1'b0;
      end
      if (early) err <= 1'b1;
      if (req_rise) begin
        act_ep <= ctl_wdata[3];
        act_wr <= ctl_wdata[1];
        moved  <= 1'b0;
        gap    <= GW'(MIN_GAP);
      end else if (cpu_go) begin
        moved <= 1'b1;
        gap   <= GW'(MIN_GAP);
      end else if (!gap_ok) begin
        gap <= gap - 1'b1;
      end
      if (cpu_go && !act_wr) dat_rdata <= mem[act_ep][rp[act_ep]];
    end

  p_wait_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !ctl_rdata[6]);
  p_wait_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |=> !ctl_rdata[6]);
  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> ctl_rdata[7]);
  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && !(ctl_wr && ctl_wdata[7])) |=> ctl_rdata[7]);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> (usb_irq && act_pipe == $past(host_pipe)));
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_done |=> !usb_irq);
  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(act_ep) && $stable(act_wr)));
endmodule

// File: tb/ep_fifo_ctrl_test.sv
module ep_fifo_ctrl_test;
  localparam int G = 6;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, dat_rd = 0, dat_wr = 0, host_ep = 0, host_push = 0, host_pop = 0;
  logic host_done = 0, host_pipe = 0;
  logic [7:0] ctl_wdata = 0, dat_wdata = 0, host_wdata = 0;
  logic [1:0] host_own = 0;
  wire  [7:0] ctl_rdata, dat_rdata, host_rdata;
  wire  [3:0] host_level;
  wire        usb_irq, act_pipe;
  wire  [1:0] zlp_pend;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  logic want = 0, cap = 0;

  always #2.5 clk = ~clk;

  ep_fifo_ctrl #(.DW(8), .DEPTH(D), .MIN_GAP(G)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic ctl(logic [7:0] b);
    ctl_wr = 1; ctl_wdata = b; @(negedge clk); ctl_wr = 0;
  endtask

  task automatic crd(logic accept, logic [7:0] exp);
    if (accept) exp_q.push_back(exp);
    want = accept; dat_rd = 1; @(negedge clk); dat_rd = 0; want = 0;
  endtask

  task automatic cwr(logic [7:0] d);
    dat_wr = 1; dat_wdata = d; @(negedge clk); dat_wr = 0;
  endtask

  task automatic hpush(logic ep, logic [7:0] d);
    host_ep = ep; host_push = 1; host_wdata = d; @(negedge clk); host_push = 0;
  endtask

  task automatic hpop(logic ep, logic [7:0] exp, string req);
    host_ep = ep; check(req, host_rdata, exp);
    host_pop = 1; @(negedge clk); host_pop = 0;
  endtask

  task automatic hdone(logic p);
    host_done = 1; host_pipe = p; @(negedge clk); host_done = 0;
  endtask

  always @(posedge clk) cap <= dat_rd & want;

  always @(negedge clk)
    if (cap) begin
      if (exp_q.size() == 0) check("R5 read data (queue empty)", 1, 0);
      else check("R5 read data order", dat_rdata, exp_q.pop_front());
    end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    check("R1 status", ctl_rdata, 8'h00);
    check("R1 irq", usb_irq, 0);
    check("R1 act_pipe", act_pipe, 0);
    check("R1 zlp", zlp_pend, 0);
    check("R1 level", host_level, 0);

    host_own = 2'b01;
    hpush(0, 8'hA1); hpush(0, 8'hA2); hpush(0, 8'hA3);
    check("R10 level after pushes", host_level, 3);
    host_own = 2'b00;
    hpush(0, 8'hFF);
    check("R6 unowned push ignored", host_level, 3);

    hdone(1);
    check("R7 irq pulse", usb_irq, 1);
    check("R7 pipe number", act_pipe, 1);
    tick(1);
    check("R7 irq one cycle", usb_irq, 0);
    hdone(0);
    check("R7 pipe number 0", act_pipe, 0);

    ctl(8'h00); ctl(8'h01);
    check("R3 not ready after request", ctl_rdata, 8'h01);
    tick(G-1);
    check("R3 not ready at gap-1", ctl_rdata, 8'h01);
    tick(1);
    check("R2 ready read", ctl_rdata, 8'h41);
    crd(1, 8'hA1);
    check("R3 not ready after access", ctl_rdata, 8'h01);
    tick(G);
    crd(1, 8'hA2);
    tick(G);
    ctl(8'h03);
    check("R9 dir latched status", ctl_rdata, 8'h43);
    crd(1, 8'hA3);
    tick(G);
    check("R5 empty not ready", ctl_rdata, 8'h03);
    ctl(8'h02);
    check("R8 read release no zlp", zlp_pend, 0);

    host_own = 2'b01; hpush(0, 8'hB1); hpush(0, 8'hB2); host_own = 2'b00;
    ctl(8'h01);
    crd(0, 8'h00);
    check("R4 early sets error", ctl_rdata, 8'h81);
    check("R4 early read ignored", dat_rdata, 8'hA3);
    tick(G);
    check("R4 error sticky", ctl_rdata, 8'hC1);
    crd(1, 8'hB1);
    ctl(8'h80);
    check("R4 error cleared", ctl_rdata, 8'h00);

    host_own = 2'b01;
    ctl(8'h01); tick(G);
    check("R6 host owned not ready", ctl_rdata, 8'h01);
    crd(0, 8'h00);
    check("R6 read ignored", dat_rdata, 8'hB1);
    ctl(8'h41);
    check("R2 bit6 write ignored", ctl_rdata, 8'h01);
    host_own = 2'b00; #1;
    check("R6 ready after release", ctl_rdata, 8'h41);
    tick(1);
    crd(1, 8'hB2);
    ctl(8'h00);

    ctl(8'h0A); ctl(8'h0B); tick(G);
    check("R2 ready write", ctl_rdata, 8'h4B);
    for (int i = 0; i < D; i++) begin
      cwr(8'hC0 + 8'(i)); tick(G);
    end
    check("R10 full not ready", ctl_rdata, 8'h0B);
    cwr(8'hEE);
    ctl(8'h09); ctl(8'h08);
    check("R8 write with data no zlp", zlp_pend, 0);
    host_own = 2'b10; host_ep = 1; #1;
    check("R10 depth stored", host_level, D);
    for (int i = 0; i < D; i++) hpop(1, 8'hC0 + 8'(i), "R10 write data order");
    check("R10 extra write dropped", host_level, 0);
    host_own = 2'b00;

    ctl(8'h02); ctl(8'h03); tick(G);
    check("R2 zlp ready", ctl_rdata, 8'h43);
    ctl(8'h01); ctl(8'h00);
    check("R8 zlp set", zlp_pend, 2'b01);
    hdone(1);
    check("R8 other pipe keeps zlp", zlp_pend, 2'b01);
    hdone(0);
    check("R8 zlp cleared", zlp_pend, 2'b00);

    tick(2);
    check("R5 all reads seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule